// File: doc/BRIEF.md
# Next Program Counter Unit

This block chooses the address of the following instruction for a 32-bit RISC core whose instructions are word aligned. Each cycle it takes a decoded control-flow kind and the operands that kind needs. From these it computes the next program counter and loads it into its own PC register on the clock edge. The operands are a 16-bit branch displacement, a 26-bit jump field, a register value for indirect jumps, and the result of the register equality compare.

For a call, the block also presents the return address, which is the sequential address, together with a strobe that tells the register file to write that address into register 31. A halt kind freezes the PC. The block then stays halted, whatever its inputs, until a synchronous reset returns the PC to zero.

Top module: `npc_unit`

## Requirements
- R1: With flow kind 0 (sequential) or the unused code 7, the next PC is PC + 4, wrapping modulo 2^32, and the PC register takes it on the following edge.
- R2: With flow kind 1 (branch if equal), the next PC is the branch target when `operandsEqual` is 1, and PC + 4 otherwise.
- R3: With flow kind 2 (branch if not equal), the next PC is the branch target when `operandsEqual` is 0, and PC + 4 otherwise.
- R4: The branch target is PC + 4 plus the 16-bit displacement, sign-extended and shifted left by two, so displacement 0xFFFF steps back one word from PC + 4.
- R5: With flow kind 3 (jump), the next PC is bits [31:28] of PC + 4, followed by the 26-bit jump field, followed by two zero bits.
- R6: With flow kind 4 (call), the next PC is the R5 jump target, `linkValue` equals PC + 4, and `linkWrite` is 1.
- R7: With flow kind 5 (register jump), the next PC equals `regTarget`.
- R8: With flow kind 6 (halt), the next PC equals the current PC, and `halted` is 1 after the following edge.
- R9: Once `halted` is 1, every flow kind is ignored: the next PC equals the current PC, the PC does not change, and `linkWrite` stays 0.
- R10: A synchronous reset sets the PC to 0 and `halted` to 0, and it is the only way to leave the halted state.
- R11: `linkWrite` is 0 for every flow kind other than 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flowKind | input | 3 | Control-flow kind: 0 seq, 1 beq, 2 bne, 3 jump, 4 call, 5 register jump, 6 halt |
| operandsEqual | input | 1 | 1 when the two compared registers hold equal values |
| branchOffset | input | 16 | Signed word displacement for branches |
| jumpField | input | 26 | Word index field for jump and call |
| regTarget | input | 32 | Destination address for register jumps |
| pcCurrent | output | 32 | Registered program counter |
| pcNext | output | 32 | Combinational next program counter |
| linkValue | output | 32 | Return address (PC + 4) |
| linkWrite | output | 1 | Write strobe for the return address into register 31 |
| halted | output | 1 | Registered halted status |

## Verification
`pcNext`, `linkValue` and `linkWrite` follow the inputs in the same cycle, with no register in between. `pcCurrent` changes exactly one edge after the inputs that chose it. `halted` rises one edge after a halt kind is presented. The bench drives inputs on the falling edge and samples the combinational outputs shortly afterwards, before the rising edge. It then reads `pcCurrent` and `halted` at the next falling edge, so each result is seen in the cycle it is due and never one cycle late. The bench sets the PC to known values with register jumps, which lets each target formula start from addresses chosen to expose sign extension, wrap-around and the upper-bit merge of the jump target.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;

  typedef enum logic [2:0] {
    FLOW_SEQ  = 3'd0,
    FLOW_BEQ  = 3'd1,
    FLOW_BNE  = 3'd2,
    FLOW_JUMP = 3'd3,
    FLOW_CALL = 3'd4,
    FLOW_REG  = 3'd5,
    FLOW_HALT = 3'd6
  } flow_e;

  // Strobes from the control into the datapath. At most one target select is high.
  typedef struct packed {
    logic takeSeq;
    logic takeBranch;
    logic takeJump;
    logic takeReg;
    logic holdPc;
    logic writeLink;
  } pc_strobe_t;

endpackage

// File: rtl/npc_ctrl.sv
`timescale 1ns/1ps
module npc_ctrl
  import npc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] flowKind,
  input  logic       operandsEqual,
  output pc_strobe_t strobe,
  output logic       halted
);

  logic haltedQ;

  // Halt is sticky: only reset clears it.
  always_ff @(posedge clk) begin
    if (rst) begin
      haltedQ <= 1'b0;
    end else if (!haltedQ && flowKind == FLOW_HALT) begin
      haltedQ <= 1'b1;
    end
  end

  always_comb begin
    strobe = '0;
    if (haltedQ) begin
      strobe.holdPc = 1'b1;
    end else begin
      case (flowKind)
        FLOW_SEQ: strobe.takeSeq = 1'b1;
        FLOW_BEQ: begin
          strobe.takeBranch = operandsEqual;
          strobe.takeSeq    = !operandsEqual;
        end
        FLOW_BNE: begin
          strobe.takeBranch = !operandsEqual;
          strobe.takeSeq    = operandsEqual;
        end
        FLOW_JUMP: strobe.takeJump = 1'b1;
        FLOW_CALL: begin
          strobe.takeJump  = 1'b1;
          strobe.writeLink = 1'b1;
        end
        FLOW_REG:  strobe.takeReg = 1'b1;
        FLOW_HALT: strobe.holdPc  = 1'b1;
        default:   strobe.takeSeq = 1'b1;
      endcase
    end
  end

  assign halted = haltedQ;

  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!haltedQ && flowKind == FLOW_HALT) |=> haltedQ); // R8

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    haltedQ |=> haltedQ); // R9

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $countones({strobe.takeSeq, strobe.takeBranch, strobe.takeJump,
                strobe.takeReg, strobe.holdPc}) == 1); // R1

endmodule

// File: rtl/npc_datapath.sv
`timescale 1ns/1ps
module npc_datapath
  import npc_pkg::*;
#(
  parameter int               ADDR_W   = 32,
  parameter int               OFF_W    = 16,
  parameter int               JMP_W    = 26,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  pc_strobe_t        strobe,
  input  logic [OFF_W-1:0]  branchOffset,
  input  logic [JMP_W-1:0]  jumpField,
  input  logic [ADDR_W-1:0] regTarget,
  output logic [ADDR_W-1:0] pcCurrent,
  output logic [ADDR_W-1:0] pcNext,
  output logic [ADDR_W-1:0] linkValue,
  output logic              linkWrite
);

  localparam int EXT_W = ADDR_W - OFF_W - 2;
  localparam int HI_W  = ADDR_W - JMP_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] pcPlus4;
  logic [ADDR_W-1:0] offsetExt;
  logic [ADDR_W-1:0] branchTarget;
  logic [ADDR_W-1:0] jumpTarget;

  assign pcPlus4      = pcQ + STEP;
  assign offsetExt    = {{EXT_W{branchOffset[OFF_W-1]}}, branchOffset, 2'b00};
  assign branchTarget = pcPlus4 + offsetExt;

  // The jump target keeps the region bits of PC + 4 when the field is narrower than the address.
  generate
    if (HI_W > 0) begin : g_region
      assign jumpTarget = {pcPlus4[ADDR_W-1 -: HI_W], jumpField, 2'b00};
    end else begin : g_flat
      logic [JMP_W+1:0] fullField;
      assign fullField  = {jumpField, 2'b00};
      assign jumpTarget = fullField[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    pcNext = pcPlus4;
    if (strobe.holdPc) begin
      pcNext = pcQ;
    end else if (strobe.takeBranch) begin
      pcNext = branchTarget;
    end else if (strobe.takeJump) begin
      pcNext = jumpTarget;
    end else if (strobe.takeReg) begin
      pcNext = regTarget;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ <= RESET_PC;
    end else begin
      pcQ <= pcNext;
    end
  end

  assign pcCurrent = pcQ;
  assign linkValue = pcPlus4;
  assign linkWrite = strobe.writeLink;

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    strobe.takeSeq |=> pcQ == $past(pcQ) + STEP); // R1

  AST_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
    strobe.takeReg |=> pcQ == $past(regTarget)); // R7

  AST_CALL_LINK: assert property (@(posedge clk) disable iff (rst)
    strobe.writeLink |=> pcQ == $past(jumpTarget)); // R6

  AST_HOLD_PC: assert property (@(posedge clk) disable iff (rst)
    strobe.holdPc |=> pcQ == $past(pcQ)); // R8

  AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    strobe.takeBranch |=> pcQ[1:0] == $past(pcQ[1:0])); // R4

endmodule

// File: rtl/npc_unit.sv
`timescale 1ns/1ps
module npc_unit
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int JMP_W  = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        flowKind,
  input  logic              operandsEqual,
  input  logic [OFF_W-1:0]  branchOffset,
  input  logic [JMP_W-1:0]  jumpField,
  input  logic [ADDR_W-1:0] regTarget,
  output logic [ADDR_W-1:0] pcCurrent,
  output logic [ADDR_W-1:0] pcNext,
  output logic [ADDR_W-1:0] linkValue,
  output logic              linkWrite,
  output logic              halted
);

  pc_strobe_t strobe;

  npc_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .flowKind      (flowKind),
    .operandsEqual (operandsEqual),
    .strobe        (strobe),
    .halted        (halted)
  );

  npc_datapath #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .JMP_W    (JMP_W),
    .RESET_PC ('0)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .branchOffset (branchOffset),
    .jumpField    (jumpField),
    .regTarget    (regTarget),
    .pcCurrent    (pcCurrent),
    .pcNext       (pcNext),
    .linkValue    (linkValue),
    .linkWrite    (linkWrite)
  );

endmodule

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;
  import npc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  flowKind = 3'd0;
  logic        operandsEqual = 1'b0;
  logic [15:0] branchOffset = '0;
  logic [25:0] jumpField = '0;
  logic [31:0] regTarget = '0;
  logic [31:0] pcCurrent, pcNext, linkValue;
  logic        linkWrite, halted;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  logic [31:0] seenNext, seenLink;
  logic        seenLinkWr;

  always #10 clk = ~clk;

  npc_unit u_dut (
    .clk(clk), .rst(rst), .flowKind(flowKind), .operandsEqual(operandsEqual),
    .branchOffset(branchOffset), .jumpField(jumpField), .regTarget(regTarget),
    .pcCurrent(pcCurrent), .pcNext(pcNext), .linkValue(linkValue),
    .linkWrite(linkWrite), .halted(halted)
  );

  task automatic check(input string req, input logic [31:0] actual, input logic [31:0] expected);
    checkCount++;
    if (actual !== expected) begin
      failCount++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, actual, expected);
    end
  endtask

  // Called at a falling edge: drive, sample the combinational outputs, then pass one rising edge.
  task automatic step(input logic [2:0] kind, input logic eq, input logic [15:0] off,
                      input logic [25:0] jf, input logic [31:0] rt);
    flowKind = kind; operandsEqual = eq; branchOffset = off; jumpField = jf; regTarget = rt;
    #2;
    seenNext = pcNext; seenLink = linkValue; seenLinkWr = linkWrite;
    @(negedge clk);
  endtask

  task automatic setPc(input logic [31:0] value);
    step(3'd5, 1'b0, 16'h0, 26'h0, value);
  endtask

  task automatic doReset();
    rst = 1'b1; flowKind = 3'd0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check("R10 reset pc", pcCurrent, 32'h0);
    check("R10 reset halted", {31'b0, halted}, 32'h0);
  endtask

  task automatic testSequential();
    step(3'd0, 1'b0, 16'h0, 26'h0, 32'h0);
    check("R1 seq next", seenNext, 32'h4);
    check("R1 seq pc", pcCurrent, 32'h4);
    check("R11 seq no link", {31'b0, seenLinkWr}, 32'h0);
    setPc(32'hFFFF_FFFC);
    step(3'd0, 1'b0, 16'h0, 26'h0, 32'h0);
    check("R1 wrap", pcCurrent, 32'h0);
    step(3'd7, 1'b1, 16'h0010, 26'h0, 32'h0);
    check("R1 code 7 sequential", pcCurrent, 32'h4);
  endtask

  task automatic testBranches();
    setPc(32'h0000_0100);
    step(3'd1, 1'b1, 16'h0004, 26'h0, 32'h0);
    check("R2 beq taken", pcCurrent, 32'h0000_0114);
    step(3'd1, 1'b0, 16'h0004, 26'h0, 32'h0);
    check("R2 beq fallthrough", pcCurrent, 32'h0000_0118);
    step(3'd2, 1'b0, 16'h0008, 26'h0, 32'h0);
    check("R3 bne taken", pcCurrent, 32'h0000_013C);
    step(3'd2, 1'b1, 16'h0008, 26'h0, 32'h0);
    check("R3 bne fallthrough", pcCurrent, 32'h0000_0140);
    step(3'd1, 1'b1, 16'hFFFF, 26'h0, 32'h0);
    check("R4 negative one word", pcCurrent, 32'h0000_0140);
    step(3'd2, 1'b0, 16'h8000, 26'h0, 32'h0);
    check("R4 most negative", pcCurrent, 32'hFFFE_0144);
    check("R11 branch no link", {31'b0, seenLinkWr}, 32'h0);
  endtask

  task automatic testJumps();
    setPc(32'hA000_0010);
    step(3'd3, 1'b0, 16'h0, 26'h000_0040, 32'h0);
    check("R5 jump next", seenNext, 32'hA000_0100);
    check("R5 jump pc", pcCurrent, 32'hA000_0100);
    setPc(32'h5FFF_FFF0);
    step(3'd4, 1'b0, 16'h0, 26'h3FF_FFFF, 32'h0);
    check("R6 call link", seenLink, 32'h5FFF_FFF4);
    check("R6 call strobe", {31'b0, seenLinkWr}, 32'h1);
    check("R6 call pc", pcCurrent, 32'h5FFF_FFFC);
    setPc(32'hFFFF_FFFC);
    step(3'd3, 1'b0, 16'h0, 26'h000_0001, 32'h0);
    check("R5 region from pc+4", pcCurrent, 32'h0000_0004);
    step(3'd5, 1'b0, 16'h0, 26'h0, 32'h1234_5678);
    check("R7 register jump", pcCurrent, 32'h1234_5678);
    check("R11 register jump no link", {31'b0, seenLinkWr}, 32'h0);
  endtask

  task automatic testHalt();
    setPc(32'h0000_0040);
    step(3'd6, 1'b0, 16'h0, 26'h0, 32'h0);
    check("R8 halt next", seenNext, 32'h0000_0040);
    check("R8 halt pc", pcCurrent, 32'h0000_0040);
    check("R8 halted set", {31'b0, halted}, 32'h1);
    step(3'd5, 1'b0, 16'h0, 26'h0, 32'h0000_0999);
    check("R9 reg jump ignored", pcCurrent, 32'h0000_0040);
    step(3'd4, 1'b0, 16'h0, 26'h000_0100, 32'h0);
    check("R9 call no link", {31'b0, seenLinkWr}, 32'h0);
    check("R9 call ignored", pcCurrent, 32'h0000_0040);
    step(3'd0, 1'b0, 16'h0, 26'h0, 32'h0);
    check("R9 seq ignored", seenNext, 32'h0000_0040);
    check("R9 still halted", {31'b0, halted}, 32'h1);
    doReset();
    check("R10 reset leaves halt", {31'b0, halted}, 32'h0);
    check("R10 reset pc after halt", pcCurrent, 32'h0);
    step(3'd0, 1'b0, 16'h0, 26'h0, 32'h0);
    check("R10 runs after reset", pcCurrent, 32'h4);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testSequential();
    testBranches();
    testJumps();
    testHalt();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule